// File: doc/BRIEF.md
# Addressing-mode micro-op sequencer

This block is the cycle-level control unit of an 8-bit processor with a 16-bit address bus. Every instruction becomes a short list of micro-operations. The list is written into a small queue when the opcode is fetched, and one entry runs per clock. Each micro-operation makes exactly one memory access, either a read or a write. It also updates the internal address state: a low address byte, a high address byte, a pointer byte, a pending index carry and an operand latch. Every list ends with the fetch of the next opcode. The register load that an instruction computes is committed during that following fetch, so execution overlaps the next instruction.

The block covers a subset of opcodes: register loads (immediate, zero-page, absolute, absolute indexed, pre-indexed indirect and post-indexed indirect) and register stores (the same memory modes). When indexing crosses a page, the carry into the high byte is held back and added on the first data-access cycle. For loads, that correction cycle is dropped when no page is crossed. Arithmetic, interrupts and the rest of the opcode set are not part of this block. Memory sits outside. The block drives the address and the strobes from its state, and it captures read data at the clock edge that ends the cycle.

Top module: `mseq_core`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, `mem_rd` and `mem_wr` stay low and the register outputs hold 0. The first cycle after release reads the opcode at `start_pc`, with `fetch_cycle` high.
- R2: An opcode fetch reads at PC and increments PC. Recognised opcodes, in hex, are as follows. Loads: A9 A2 A0 (immediate), A5 A6 A4 (zero page), AD AE AC (absolute), BD BC (absolute+X), B9 BE (absolute+Y), A1 (pointer at operand+X), B1 (pointer at operand, then +Y). Stores: 85 86 84 (zero page), 8D 8E 8C (absolute), 9D (absolute+X), 99 (absolute+Y), 81 (pointer at operand+X), 91 (pointer at operand, then +Y). Any other opcode takes only its fetch cycle, and the next cycle fetches at PC+1.
- R3: A load targets A when opcode bits [1:0] are 01, X when they are 10, and Y otherwise. The new value appears on the register outputs in the cycle after the next opcode fetch, and never in any other cycle.
- R4: An immediate load reads its operand at PC+1 (two cycles in all). A zero-page access reads the operand byte b, then accesses address 0x00b.
- R5: An absolute access reads the low byte at PC+1 and the high byte at PC+2, then accesses {high, low}.
- R6: An indexed load adds the index to the low byte only. With no carry out, the next cycle reads the final address. With a carry, that cycle reads {high, low sum mod 256} and the cycle after it reads the corrected address. The carry is added exactly once.
- R7: An indexed store always reads {high, low sum mod 256} first, then writes at the carry-corrected address.
- R8: The mode with the pointer at operand+X first does a dummy read at 0x00b. It then reads the pointer bytes at (b+X) mod 256 and at (b+X+1) mod 256, both in page zero, and then accesses the address they form.
- R9: The mode with the pointer at operand, then +Y reads the pointer bytes at 0x00b and at (b+1) mod 256. It then adds Y with the same carry behaviour as R6 for loads and R7 for stores.
- R10: A store writes A when opcode bits [1:0] are 01, X when they are 10, and Y otherwise. Every cycle out of reset has exactly one of `mem_rd` or `mem_wr` high, and a write is always followed by an opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pc | input | ADDR_W | PC loaded at reset |
| mem_rdata | input | DATA_W | Read data, captured at the end of the access cycle |
| mem_addr | output | ADDR_W | Access address for this cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| fetch_cycle | output | 1 | This cycle is an opcode fetch |
| reg_a | output | DATA_W | Accumulator |
| reg_x | output | DATA_W | X index register |
| reg_y | output | DATA_W | Y index register |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit datum and an eight-slot micro-op queue. Its 4 KiB memory image is mirrored across the full address range, and the program starts at 0x0200. With these values the bench can place both index outcomes in one program: low-byte sums that stay in their page, and sums that carry into the next page, for loads and for stores. It can also put a pointer at 0xFF, so that the pointer's second byte wraps back to 0x00 in page zero, and a slot-eight queue has room for the longest six-entry list.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  // micro-operations, one per clock
  typedef enum logic [3:0] {
    U_FETCH,     // commit pending load, read opcode at PC, reload queue
    U_OPLO,      // read operand at PC into latch and address low
    U_OPHI,      // read operand at PC into address high
    U_OPHI_IX,   // address high from PC, X added to address low, carry kept
    U_OPHI_IY,   // address high from PC, Y added to address low, carry kept
    U_IDXX,      // dummy read in page zero, X added to pointer
    U_PTRLO,     // read pointer low, pointer advances inside page zero
    U_PTRHI,     // read pointer high, address low from pointer byte
    U_PTRHI_IY,  // read pointer high, pointer byte plus Y, carry kept
    U_READ,      // data read, pending carry folded into high byte
    U_READ_SKIP, // as U_READ, next entry dropped when no carry pending
    U_WRITE      // store selected register
  } uop_e;

  typedef enum logic [2:0] {
    AM_NONE, AM_IMM, AM_ZP, AM_ABS, AM_ABSX, AM_ABSY, AM_INDX, AM_INDY
  } amode_e;

endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic [7:0] opcode,
  output uop_e       seq [QDEPTH],
  output logic       is_load
);

  amode_e mode;
  logic   is_store;
  uop_e   last_acc;

  always_comb begin
    mode     = AM_NONE;
    is_store = 1'b0;
    case (opcode)
      8'hA9, 8'hA2, 8'hA0: mode = AM_IMM;
      8'hA5, 8'hA6, 8'hA4: mode = AM_ZP;
      8'hAD, 8'hAE, 8'hAC: mode = AM_ABS;
      8'hBD, 8'hBC:        mode = AM_ABSX;
      8'hB9, 8'hBE:        mode = AM_ABSY;
      8'hA1:               mode = AM_INDX;
      8'hB1:               mode = AM_INDY;
      8'h85, 8'h86, 8'h84: begin mode = AM_ZP;   is_store = 1'b1; end
      8'h8D, 8'h8E, 8'h8C: begin mode = AM_ABS;  is_store = 1'b1; end
      8'h9D:               begin mode = AM_ABSX; is_store = 1'b1; end
      8'h99:               begin mode = AM_ABSY; is_store = 1'b1; end
      8'h81:               begin mode = AM_INDX; is_store = 1'b1; end
      8'h91:               begin mode = AM_INDY; is_store = 1'b1; end
      default: begin mode = AM_NONE; is_store = 1'b0; end
    endcase
  end

  always_comb begin
    if (is_store) last_acc = U_WRITE;
    else          last_acc = U_READ;
  end

  assign is_load = (mode != AM_NONE) && !is_store;

  // list after the opcode fetch; unused slots are opcode fetches
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) seq[i] = U_FETCH;
    case (mode)
      AM_IMM: seq[0] = U_OPLO;
      AM_ZP: begin
        seq[0] = U_OPLO;
        seq[1] = last_acc;
      end
      AM_ABS: begin
        seq[0] = U_OPLO;
        seq[1] = U_OPHI;
        seq[2] = last_acc;
      end
      AM_ABSX, AM_ABSY: begin
        seq[0] = U_OPLO;
        if (mode == AM_ABSX) seq[1] = U_OPHI_IX;
        else                 seq[1] = U_OPHI_IY;
        if (is_store) begin
          seq[2] = U_READ;
          seq[3] = U_WRITE;
        end else begin
          seq[2] = U_READ_SKIP;
          seq[3] = U_READ;
        end
      end
      AM_INDX: begin
        seq[0] = U_OPLO;
        seq[1] = U_IDXX;
        seq[2] = U_PTRLO;
        seq[3] = U_PTRHI;
        seq[4] = last_acc;
      end
      AM_INDY: begin
        seq[0] = U_OPLO;
        seq[1] = U_PTRLO;
        seq[2] = U_PTRHI_IY;
        if (is_store) begin
          seq[3] = U_READ;
          seq[4] = U_WRITE;
        end else begin
          seq[3] = U_READ_SKIP;
          seq[4] = U_READ;
        end
      end
      default: seq[0] = U_FETCH;
    endcase
  end

endmodule

// File: rtl/mseq_uqueue.sv
module mseq_uqueue
  import mseq_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  uop_e fill [QDEPTH],
  input  logic skip,
  output uop_e cur
);

  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  uop_e           slot [QDEPTH];
  logic [PW-1:0]  ptr;

  assign cur = slot[ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < QDEPTH; i++) slot[i] <= U_FETCH;
      ptr <= '0;
    end else if (cur == U_FETCH) begin
      for (int i = 0; i < QDEPTH; i++) slot[i] <= fill[i];
      ptr <= '0;
    end else begin
      ptr <= ptr + (skip ? PW'(2) : PW'(1));
    end
  end

endmodule

// File: rtl/mseq_addr_unit.sv
module mseq_addr_unit
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_pc,
  input  uop_e              op,
  input  logic [DATA_W-1:0] rdata,
  input  logic              new_load,
  output logic [ADDR_W-1:0] addr,
  output logic              rd,
  output logic              wr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic              carry_q
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] adl, tlo, opl;
  logic [HI_W-1:0]   adh;
  logic [1:0]        sel;
  logic              pend;
  logic [DATA_W:0]   sum_ix, sum_ty;
  logic [DATA_W-1:0] idx_pick;

  assign idx_pick = (op == U_OPHI_IX) ? x_q : y_q;
  assign sum_ix   = {1'b0, adl} + {1'b0, idx_pick};
  assign sum_ty   = {1'b0, tlo} + {1'b0, y_q};

  always_comb begin
    case (op)
      U_FETCH, U_OPLO, U_OPHI, U_OPHI_IX, U_OPHI_IY: addr = pc;
      U_IDXX, U_PTRLO, U_PTRHI, U_PTRHI_IY:        addr = {{HI_W{1'b0}}, adl};
      default:                                     addr = {adh, adl};
    endcase
  end

  assign rd = !rst && (op != U_WRITE);
  assign wr = !rst && (op == U_WRITE);

  always_comb begin
    case (sel)
      2'b01:   wdata = a_q;
      2'b10:   wdata = x_q;
      default: wdata = y_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= start_pc;
      adl     <= '0;
      adh     <= '0;
      tlo     <= '0;
      opl     <= '0;
      carry_q <= 1'b0;
      sel     <= 2'b00;
      pend    <= 1'b0;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
    end else begin
      case (op)
        U_FETCH: begin
          if (pend) begin
            case (sel)
              2'b01:   a_q <= opl;
              2'b10:   x_q <= opl;
              default: y_q <= opl;
            endcase
          end
          sel  <= rdata[1:0];
          pend <= new_load;
          pc   <= pc + ADDR_W'(1);
        end
        U_OPLO: begin
          opl     <= rdata;
          adl     <= rdata;
          adh     <= '0;
          carry_q <= 1'b0;
          pc      <= pc + ADDR_W'(1);
        end
        U_OPHI: begin
          adh <= HI_W'(rdata);
          pc  <= pc + ADDR_W'(1);
        end
        U_OPHI_IX, U_OPHI_IY: begin
          adh     <= HI_W'(rdata);
          adl     <= sum_ix[DATA_W-1:0];
          carry_q <= sum_ix[DATA_W];
          pc      <= pc + ADDR_W'(1);
        end
        U_IDXX:  adl <= adl + x_q;
        U_PTRLO: begin
          tlo <= rdata;
          adl <= adl + DATA_W'(1);
        end
        U_PTRHI: begin
          adh <= HI_W'(rdata);
          adl <= tlo;
        end
        U_PTRHI_IY: begin
          adh     <= HI_W'(rdata);
          adl     <= sum_ty[DATA_W-1:0];
          carry_q <= sum_ty[DATA_W];
        end
        U_READ, U_READ_SKIP: begin
          opl     <= rdata;
          adh     <= adh + HI_W'(carry_q);
          carry_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mseq_core.sv
module mseq_core
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fetch_cycle,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_x,
  output logic [DATA_W-1:0] reg_y
);

  uop_e seq_list [QDEPTH];
  uop_e cur_op;
  logic load_op;
  logic carry_pend;
  logic drop_next;

  mseq_decode #(.QDEPTH(QDEPTH)) u_dec (
    .opcode  (mem_rdata[7:0]),
    .seq     (seq_list),
    .is_load (load_op)
  );

  assign drop_next = (cur_op == U_READ_SKIP) && !carry_pend;

  mseq_uqueue #(.QDEPTH(QDEPTH)) u_q (
    .clk  (clk),
    .rst  (rst),
    .fill (seq_list),
    .skip (drop_next),
    .cur  (cur_op)
  );

  mseq_addr_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_au (
    .clk      (clk),
    .rst      (rst),
    .start_pc (start_pc),
    .op       (cur_op),
    .rdata    (mem_rdata),
    .new_load (load_op),
    .addr     (mem_addr),
    .rd       (mem_rd),
    .wr       (mem_wr),
    .wdata    (mem_wdata),
    .a_q      (reg_a),
    .x_q      (reg_x),
    .y_q      (reg_y),
    .carry_q  (carry_pend)
  );

  assign fetch_cycle = !rst && (cur_op == U_FETCH);

endmodule

// File: rtl/mseq_core_chk.sv
module mseq_core_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] start_pc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              fetch_cycle,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_x,
  input logic [DATA_W-1:0] reg_y
);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!mem_rd && !mem_wr));

  a_r1_first_fetch: assert property (@(posedge clk)
    $fell(rst) |-> (fetch_cycle && mem_addr == $past(start_pc)));

  a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
    fetch_cycle |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r3_regs_hold: assert property (@(posedge clk) disable iff (rst)
    !fetch_cycle |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y)));

  a_r10_one_access: assert property (@(posedge clk) disable iff (rst)
    (mem_rd ^ mem_wr));

  a_r10_write_then_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> fetch_cycle);

endmodule

bind mseq_core mseq_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_pc    (start_pc),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .fetch_cycle (fetch_cycle),
  .reg_a       (reg_a),
  .reg_x       (reg_x),
  .reg_y       (reg_y)
);

// File: tb/mseq_core_test.sv
module mseq_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] start_pc = 16'h0200;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, fetch_cycle;
  logic [7:0]  mem_wdata, reg_a, reg_x, reg_y;

  always #5 clk = ~clk;

  mseq_core uut (
    .clk(clk), .rst(rst), .start_pc(start_pc), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .fetch_cycle(fetch_cycle), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y)
  );

  // 4 KiB memory mirrored over the address space
  logic [7:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

  int checks = 0;
  int errors = 0;

  // reference model state
  int    m_pc;
  int    va = 0, vx = 0, vy = 0;
  bit    pend = 0;
  int    psel = 0, pval = 0;
  int    q_addr [$];
  bit    q_wr [$];
  int    q_data [$];
  bit    q_fetch [$];
  string q_tag [$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int rdm(int a);
    return int'(mem[12'(a)]);
  endfunction

  function automatic int regv(int s);
    if (s == 1) return va;
    if (s == 2) return vx;
    return vy;
  endfunction

  task automatic push(int a, bit w, int d, bit f, string t);
    q_addr.push_back(a & 16'hFFFF);
    q_wr.push_back(w);
    q_data.push_back(d);
    q_fetch.push_back(f);
    q_tag.push_back(t);
  endtask

  task automatic access(int ea, bit st, int sel, string t);
    if (st) push(ea, 1'b1, regv(sel), 1'b0, "R10");
    else begin
      push(ea, 1'b0, -1, 1'b0, t);
      pend = 1; psel = sel; pval = rdm(ea);
    end
  endtask

  // indexed tail shared by both index modes
  task automatic indexed(int base, int idx, bit st, int sel, string t);
    int s, ea;
    s  = (base & 255) + idx;
    ea = (base + idx) & 16'hFFFF;
    if (s > 255 || st) push((base & 16'hFF00) | (s & 255), 1'b0, -1, 1'b0, st ? "R7" : "R6");
    access(ea, st, sel, t);
  endtask

  task automatic gen_instr();
    int p, op, sel, b, lo, hi, ptr;
    bit st;
    p  = m_pc;
    op = rdm(p);
    push(p, 1'b0, -1, 1'b1, "R2");
    p++;
    sel = ((op & 3) == 1) ? 1 : (((op & 3) == 2) ? 2 : 3);
    st  = (op & 8'hE0) == 8'h80;
    case (op)
      8'hA9, 8'hA2, 8'hA0: begin
        push(p, 1'b0, -1, 1'b0, "R4");
        pend = 1; psel = sel; pval = rdm(p); p++;
      end
      8'hA5, 8'hA6, 8'hA4, 8'h85, 8'h86, 8'h84: begin
        b = rdm(p); push(p, 1'b0, -1, 1'b0, "R4"); p++;
        access(b, st, sel, "R4");
      end
      8'hAD, 8'hAE, 8'hAC, 8'h8D, 8'h8E, 8'h8C: begin
        lo = rdm(p); push(p, 1'b0, -1, 1'b0, "R5"); p++;
        hi = rdm(p); push(p, 1'b0, -1, 1'b0, "R5"); p++;
        access(hi * 256 + lo, st, sel, "R5");
      end
      8'hBD, 8'hBC, 8'h9D, 8'hB9, 8'hBE, 8'h99: begin
        lo = rdm(p); push(p, 1'b0, -1, 1'b0, "R6"); p++;
        hi = rdm(p); push(p, 1'b0, -1, 1'b0, "R6"); p++;
        indexed(hi * 256 + lo, (op == 8'hBD || op == 8'hBC || op == 8'h9D) ? vx : vy,
                st, sel, "R6");
      end
      8'hA1, 8'h81: begin
        b = rdm(p); push(p, 1'b0, -1, 1'b0, "R8"); p++;
        push(b, 1'b0, -1, 1'b0, "R8");
        ptr = (b + vx) & 255;
        lo = rdm(ptr); push(ptr, 1'b0, -1, 1'b0, "R8");
        hi = rdm((ptr + 1) & 255); push((ptr + 1) & 255, 1'b0, -1, 1'b0, "R8");
        access(hi * 256 + lo, st, sel, "R8");
      end
      8'hB1, 8'h91: begin
        b = rdm(p); push(p, 1'b0, -1, 1'b0, "R9"); p++;
        lo = rdm(b); push(b, 1'b0, -1, 1'b0, "R9");
        hi = rdm((b + 1) & 255); push((b + 1) & 255, 1'b0, -1, 1'b0, "R9");
        indexed(hi * 256 + lo, vy, st, sel, "R9");
      end
      default: ;
    endcase
    m_pc = p & 16'hFFFF;
  endtask

  task automatic step();
    int a, d; bit w, f; string t;
    check(reg_a == va[7:0], "R3", "reg_a", reg_a, va);
    check(reg_x == vx[7:0], "R3", "reg_x", reg_x, vx);
    check(reg_y == vy[7:0], "R3", "reg_y", reg_y, vy);
    if (q_addr.size() == 0) begin
      if (pend) begin
        if (psel == 1) va = pval; else if (psel == 2) vx = pval; else vy = pval;
        pend = 0;
      end
      gen_instr();
    end
    a = q_addr.pop_front(); w = q_wr.pop_front(); d = q_data.pop_front();
    f = q_fetch.pop_front(); t = q_tag.pop_front();
    check(mem_addr == a[15:0], t, "mem_addr", mem_addr, a);
    check(mem_wr == w && mem_rd == !w, t, "strobes", {mem_rd, mem_wr}, {!w, w});
    check(fetch_cycle == f, (f ? "R2" : t), "fetch_cycle", fetch_cycle, f);
    if (w) check(mem_wdata == d[7:0], "R10", "mem_wdata", mem_wdata, d);
  endtask

  task automatic put(int a, int v);
    mem[12'(a)] = 8'(v);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    // program at 0x0200
    put(16'h200, 8'hA2); put(16'h201, 8'h05);                       // X=05 imm
    put(16'h202, 8'hA0); put(16'h203, 8'hF0);                       // Y=F0 imm
    put(16'h204, 8'hA9); put(16'h205, 8'h3C);                       // A=3C imm
    put(16'h206, 8'h85); put(16'h207, 8'h40);                       // store A zp
    put(16'h208, 8'hA6); put(16'h209, 8'h41);                       // X from zp
    put(16'h20A, 8'hAD); put(16'h20B, 8'h00); put(16'h20C, 8'h03);  // A abs
    put(16'h20D, 8'hBD); put(16'h20E, 8'h10); put(16'h20F, 8'h03);  // A abs+X no carry
    put(16'h210, 8'hBD); put(16'h211, 8'hFC); put(16'h212, 8'h03);  // A abs+X carry
    put(16'h213, 8'hB9); put(16'h214, 8'h20); put(16'h215, 8'h03);  // A abs+Y carry
    put(16'h216, 8'h9D); put(16'h217, 8'h80); put(16'h218, 8'h04);  // store abs+X
    put(16'h219, 8'h99); put(16'h21A, 8'h30); put(16'h21B, 8'h04);  // store abs+Y carry
    put(16'h21C, 8'hA1); put(16'h21D, 8'hF5);                       // ptr at FC
    put(16'h21E, 8'hA1); put(16'h21F, 8'hF8);                       // ptr at FF wraps
    put(16'h220, 8'hB1); put(16'h221, 8'h60);                       // +Y no carry
    put(16'h222, 8'hB1); put(16'h223, 8'h62);                       // +Y carry
    put(16'h224, 8'h91); put(16'h225, 8'hFF);                       // store, ptr wraps
    put(16'h226, 8'h86); put(16'h227, 8'h42);                       // store X zp
    put(16'h228, 8'h8C); put(16'h229, 8'h50); put(16'h22A, 8'h03);  // store Y abs
    put(16'h22B, 8'hEA);                                            // unrecognised
    put(16'h22C, 8'hA4); put(16'h22D, 8'h41);                       // Y from zp
    put(16'h22E, 8'hBE); put(16'h22F, 8'h00); put(16'h230, 8'h03);  // X abs+Y
    put(16'h231, 8'hBC); put(16'h232, 8'hF9); put(16'h233, 8'h02);  // Y abs+X carry
    put(16'h234, 8'h81); put(16'h235, 8'h10);                       // store via ptr+X
    put(16'h236, 8'h8E); put(16'h237, 8'h51); put(16'h238, 8'h03);  // store X abs
    put(16'h239, 8'h84); put(16'h23A, 8'h43);                       // store Y zp
    put(16'h23B, 8'hAE); put(16'h23C, 8'h00); put(16'h23D, 8'h03);  // X abs
    // data
    put(16'h041, 8'h07); put(16'h300, 8'h5A); put(16'h317, 8'h21);
    put(16'h403, 8'h99); put(16'h410, 8'h44); put(16'h0FC, 8'h00);
    put(16'h0FD, 8'h06); put(16'h600, 8'h77); put(16'h0FF, 8'h34);
    put(16'h000, 8'h06); put(16'h634, 8'h88); put(16'h060, 8'h05);
    put(16'h061, 8'h07); put(16'h7F5, 8'h12); put(16'h062, 8'h20);
    put(16'h063, 8'h07); put(16'h810, 8'h13); put(16'h307, 8'h0B);
    put(16'h304, 8'h66); put(16'h01B, 8'h00); put(16'h01C, 8'h05);

    m_pc = 16'h0200;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    check(reg_a == 0 && reg_x == 0 && reg_y == 0, "R1", "regs in reset",
          {reg_a, reg_x, reg_y}, 0);
    @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(fetch_cycle && mem_addr == start_pc, "R1", "first fetch", mem_addr, start_pc);
    step();
    for (int n = 0; n < 299; n++) begin
      @(negedge clk);
      step();
    end
    // stored values (R10 register choice, R7/R8/R9 addresses)
    check(mem[12'h040] == 8'h3C, "R10", "zp store A", mem[12'h040], 8'h3C);
    check(mem[12'h487] == 8'h44, "R7", "abs+X store", mem[12'h487], 8'h44);
    check(mem[12'h520] == 8'h44, "R7", "abs+Y store carry", mem[12'h520], 8'h44);
    check(mem[12'h724] == 8'h13, "R9", "ptr+Y store wrap", mem[12'h724], 8'h13);
    check(mem[12'h042] == 8'h07, "R10", "zp store X", mem[12'h042], 8'h07);
    check(mem[12'h350] == 8'hF0, "R10", "abs store Y", mem[12'h350], 8'hF0);
    check(mem[12'h500] == 8'h13, "R8", "ptr+X store", mem[12'h500], 8'h13);
    check(mem[12'h351] == 8'h0B, "R10", "abs store X", mem[12'h351], 8'h0B);
    check(mem[12'h043] == 8'h66, "R10", "zp store Y", mem[12'h043], 8'h66);
    check(reg_a == 8'h13, "R3", "final A", reg_a, 8'h13);
    check(reg_x == 8'h5A, "R3", "final X", reg_x, 8'h5A);
    check(reg_y == 8'h66, "R3", "final Y", reg_y, 8'h66);
    finish_run();
  end

endmodule